// File: doc/BRIEF.md
# Matrix key scanner with two-pass confirmation

This block watches a keypad wired as a grid of drive rows and pulled-up sense columns. It runs from a slow free-running scan clock. While idle it pulls every row low, so a press on any key takes some column low. That low column starts a scan. The scan lowers one row at a time for a fixed slot and records which columns read low at the end of that slot. Two complete passes run back to back. The result is kept only when both passes produce the same, non-empty bitmap.

An accepted bitmap is copied into a holding register and a request flag is raised for the host. No scan starts while the host holds its select line low, and any scan in progress is abandoned when the select line goes low. While a request is pending, scanning is locked out and the held bitmap does not change. The host releases the request by taking its select line high again. After that, a key that is still held down is scanned again and raises a fresh request.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, `req` is 0, `key_image` is all zeros and every bit of `drive_n` is 0 (all rows driven low).
- R2: While idle, all rows are driven low. A scan starts when any `sense_n` bit is low, the host is deselected (`cs_n` high) and no request is pending.
- R3: During a scan, rows are activated in order 0, 1, 2, 3. Each row is held low for SLOT (128) clock cycles while the other rows are high. One pass therefore lasts 4×SLOT cycles, two passes are made, and `drive_n` returns to all zeros afterwards.
- R4: In `key_image`, bit index r*COLS+c (0-based; equal to r*6+c+1 when counting from 1) is 1 when the key at row r and column c is pressed. Several keys pressed together each set their own bit.
- R5: A request is raised only when the two passes give identical, non-zero bitmaps. Otherwise the scanner returns to idle with `req` left at 0.
- R6: `req` rises no more than 1408 clock cycles after a key press that starts a scan.
- R7: No scan runs while `cs_n` is low. A scan in progress is abandoned when `cs_n` goes low, and `drive_n` returns to all zeros.
- R8: While `req` is 1, no scan runs (`drive_n` stays all zeros) and `key_image` holds its value, even when the pressed keys change.
- R9: A rising edge of `cs_n` clears `req`. If a key is still held after that, it is scanned again and a new request carries its bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host select, active low; a rising edge releases a request |
| sense_n | input | COLS | Column sense lines, pulled up; low means connected to a driven row |
| drive_n | output | ROWS | Row drive lines; a 0 pulls the row low |
| key_image | output | ROWS*COLS | Held bitmap of pressed keys |
| req | output | 1 | Request flag: a confirmed bitmap is waiting |

## Verification
The assertions assume that `cs_n` and `sense_n` are fully asynchronous to the scanner and pass only through its two-flop synchronizers. They also assume that a column reading reflects the row drive pattern long before the sample point at the end of a slot.

The bench models an ideal keypad in which every key has a series diode. Column c reads low only when a pressed key in that column sits on a row that is currently driven low, so no ghost keys appear. Keys and `cs_n` change only at falling clock edges. Key changes are timed against the known slot positions, so that a disagreement between the two passes falls into a chosen pass.

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
  parameter int ROWS = 4,
  parameter int COLS = 6,
  parameter int SLOT = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic [COLS-1:0]      sense_n,
  output logic [ROWS-1:0]      drive_n,
  output logic [ROWS*COLS-1:0] key_image,
  output logic                 req
);
  localparam int KEYS = ROWS * COLS;
  localparam int CW   = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [COLS-1:0] sense_m, sense_s;
  logic            cs_m, cs_s, cs_q;
  logic            scanning, pass, mism;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   row;
  logic [KEYS-1:0] first;

  wire [COLS-1:0] seen     = ~sense_s;
  wire [COLS-1:0] prev_row = first[row*COLS +: COLS];
  wire            slot_end = (cnt == CW'(SLOT-1));
  wire            last_row = (row == RW'(ROWS-1));
  wire            mism_now = mism | (prev_row != seen);

  assign drive_n = scanning ? ~(ROWS'(1) << row) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_m   <= '1;
      sense_s   <= '1;
      cs_m      <= 1'b0;
      cs_s      <= 1'b0;
      cs_q      <= 1'b0;
      scanning  <= 1'b0;
      pass      <= 1'b0;
      mism      <= 1'b0;
      cnt       <= '0;
      row       <= '0;
      first     <= '0;
      key_image <= '0;
      req       <= 1'b0;
    end else begin
      sense_m <= sense_n;
      sense_s <= sense_m;
      cs_m    <= cs_n;
      cs_s    <= cs_m;
      cs_q    <= cs_s;
      if (cs_s && !cs_q) req <= 1'b0;
      if (!scanning) begin
        if (cs_s && !req && !(&sense_s)) begin
          scanning <= 1'b1;
          pass     <= 1'b0;
          mism     <= 1'b0;
          cnt      <= '0;
          row      <= '0;
        end
      end else if (!cs_s) begin
        scanning <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (slot_end) begin
          cnt <= '0;
          if (!pass) first[row*COLS +: COLS] <= seen;
          else       mism <= mism_now;
          if (last_row) begin
            row <= '0;
            if (!pass) begin
              pass <= 1'b1;
            end else begin
              scanning <= 1'b0;
              if (!mism_now && first != '0) begin
                key_image <= first;
                req       <= 1'b1;
              end
            end
          end else begin
            row <= row + 1'b1;
          end
        end
      end
    end
  end

  assert_one_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_n == '0) || ($countones(drive_n) == ROWS-1));

  assert_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (key_image != '0));

  assert_req_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(cs_s));

  assert_abort_on_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (drive_n == '0));

  assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (drive_n == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && $past(req)) |-> $stable(key_image));
endmodule

// File: tb/key_matrix_scanner_bench.sv
module key_matrix_scanner_bench;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int SLOT = 128;
  localparam int KEYS = ROWS * COLS;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            cs_n = 1;
  logic [COLS-1:0] sense_n;
  logic [ROWS-1:0] drive_n;
  logic [KEYS-1:0] key_image;
  logic            req;
  logic [KEYS-1:0] pressed = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  key_matrix_scanner #(.ROWS(ROWS), .COLS(COLS), .SLOT(SLOT)) u_key_matrix_scanner (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sense_n(sense_n),
    .drive_n(drive_n), .key_image(key_image), .req(req));

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      sense_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (pressed[r*COLS+c] && !drive_n[r]) sense_n[c] = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic release_cs;
    cs_n = 0; tick(8);
    cs_n = 1; tick(6);
  endtask

  task automatic press_and_confirm(input string tag, input logic [KEYS-1:0] m);
    int n;
    pressed = m;
    wait_req(n);
    check({tag, " R6 latency ok"}, (n <= 1408), 1);
    check({tag, " R4 image"}, key_image, m);
    pressed = '0;
    tick(2);
    release_cs;
    check({tag, " R9 req cleared"}, req, 0);
  endtask

  initial begin
    int n;
    int run;
    logic [KEYS-1:0] held;
    tick(3);
    check("R1 req", req, 0);
    check("R1 image", key_image, 0);
    check("R1 drive", drive_n, 0);
    rst_n = 1;
    tick(3);
    check("R2 idle drive", drive_n, 0);
    tick(200);
    check("R2 no key no scan", drive_n, 0);

    // R3 slot timing on one press
    pressed = KEYS'(1) << 9;
    while (drive_n == '0) @(negedge clk);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < ROWS; r++) begin
        run = 0;
        while (drive_n == ROWS'(~(ROWS'(1) << r)) && run < 1000) begin
          @(negedge clk); run++;
        end
        check($sformatf("R3 pass%0d row%0d slot", p, r), run, SLOT);
      end
    check("R3 back to idle drive", drive_n, 0);
    tick(3);
    check("R3 req after two passes", req, 1);
    check("R4 bit 9 image", key_image, KEYS'(1) << 9);
    pressed = '0; tick(2); release_cs;

    // R4 sweep of single keys
    for (int k = 0; k < KEYS; k++)
      press_and_confirm($sformatf("single r%0d c%0d", k / COLS, k % COLS), KEYS'(1) << k);
    // R4 pairs and a row/column mix
    for (int k = 0; k < KEYS/2; k++)
      press_and_confirm($sformatf("pair %0d", k), (KEYS'(1) << k) | (KEYS'(1) << (KEYS-1-k)));
    press_and_confirm("full row 2", KEYS'((1 << COLS) - 1) << (2*COLS));
    press_and_confirm("column 3", KEYS'(1) << 3 | KEYS'(1) << (COLS+3) | KEYS'(1) << (2*COLS+3) | KEYS'(1) << (3*COLS+3));

    // R5 disagreement: row 0 seen in pass 1, gone in pass 2
    pressed = KEYS'(1) << 2;
    tick(300);
    pressed = '0;
    tick(2000);
    check("R5 mismatch no req", req, 0);
    check("R5 mismatch idle", drive_n, 0);
    // R5 empty: released before the first sample
    pressed = KEYS'(1) << 20;
    tick(50);
    pressed = '0;
    tick(2000);
    check("R5 empty no req", req, 0);

    // R7 lockout while selected
    cs_n = 0; tick(5);
    pressed = KEYS'(1) << 15;
    tick(2000);
    check("R7 selected no scan", drive_n, 0);
    check("R7 selected no req", req, 0);
    cs_n = 1;
    wait_req(n);
    check("R7 scan after deselect", req, 1);
    check("R7 image", key_image, KEYS'(1) << 15);
    pressed = '0; tick(2); release_cs;

    // R7 abort mid-scan
    pressed = KEYS'(1) << 4;
    tick(600);
    cs_n = 0; tick(6);
    check("R7 abort drive", drive_n, 0);
    tick(1500);
    check("R7 abort no req", req, 0);
    pressed = '0; cs_n = 1; tick(20);

    // R8 lockout while request pending
    pressed = KEYS'(1) << 7;
    wait_req(n);
    held = key_image;
    pressed = KEYS'(1) << 18;
    tick(3000);
    check("R8 req held", req, 1);
    check("R8 image unchanged", key_image, held);
    check("R8 no scan", drive_n, 0);
    // R9 release with a new key held
    release_cs;
    check("R9 cleared", req, 0);
    wait_req(n);
    check("R9 new req", req, 1);
    check("R9 new image", key_image, KEYS'(1) << 18);
    // R9 same key still held
    release_cs;
    wait_req(n);
    check("R9 rescan same key", key_image, KEYS'(1) << 18);
    check("R9 rescan latency", (n <= 1408), 1);
    pressed = '0; tick(2); release_cs;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule